// File: doc/BRIEF.md
# Buffered PWM Reload Control Unit

This block holds the control settings of a PWM generator and decides when each setting takes effect. Software writes one 8-bit control byte holding four fields: a reload-rate code, three per-pair correction selects and a clock-divider code. Every write lands in a buffered copy. Each field has its own rule for when a working copy takes the buffered value, so a setting never changes partway through a PWM period. A read always returns the buffered copy.

Inside, a divider stage slows the clock by 1, 2, 4 or 8. A period counter then counts from zero up to one less than the `period` input, and a one-clock cycle-start pulse marks each return to zero. A load-cycle sequencer counts PWM cycles and raises a reload pulse at the end of every load cycle. A load cycle lasts 1, 2, 4 or 8 PWM cycles. A load-okay flag, armed by a software pulse, decides whether a new divider value may be taken. The per-pair correction outputs tell the duty logic, for each pair under software correction, which of its two duty registers to use.

The sequencer is built from two small state machines. The load-cycle machine has state LD_COUNT, in which more PWM cycles remain in the load cycle, and state LD_FINAL, in which the next wrap ends it. At a wrap, LD_COUNT stays in LD_COUNT or moves to LD_FINAL once the next wrap will be the last one. At a wrap, LD_FINAL issues the reload and moves to LD_FINAL if the new length is one cycle, otherwise to LD_COUNT. The load-okay machine has states OK_IDLE and OK_ARMED. A set pulse moves it to OK_ARMED. A reload returns it to OK_IDLE unless a set pulse arrives in that same cycle, in which case it stays in OK_ARMED.

Top module: `pwm_reload_ctl`

## Requirements
- R1: The control byte layout is: bits 7:6 reload-rate code, bit 5 unused and always read as 0, bit 4 pair 1 correction select, bit 3 pair 2, bit 2 pair 3, bits 1:0 divider code.
- R2: After reset, the read value, `act_rate`, `act_div`, `pair_sel`, `load_ok`, `reload` and `cycle_start` are all zero.
- R3: `pwm_count` runs from 0 to `period`-1, advancing once every 2^`act_div` clocks. On its return to 0, `cycle_start` is high for one clock, with `pwm_count` equal to 0. Successive pulses are `period`*2^`act_div` clocks apart.
- R4: `reload` is raised only together with `cycle_start`. With reload-rate codes 00, 01, 10 and 11 it comes on every 1st, 2nd, 4th and 8th cycle start respectively.
- R5: A new reload-rate code appears on `act_rate` at the cycle start that ends the current load cycle, whether or not load-okay is set. The new length then governs the next load cycle.
- R6: A new divider code appears on `act_div` only at a cycle start at which load-okay is set. A cycle start without load-okay leaves `act_div` unchanged.
- R7: A one-clock `load_ok_set` pulse sets `load_ok`, and a reload clears it. A set pulse in the same clock as the reload edge leaves `load_ok` at 1.
- R8: The correction selects are taken into the working copy at every cycle start. A write in the clock that ends a PWM cycle is taken at the following cycle start.
- R9: `pair_sel[i]` equals the working correction select of pair i+1 ANDed with `sw_corr[i]`. A value of 1 selects duty register 2 and 0 selects duty register 1.
- R10: A read returns the buffered byte just written, not the working settings in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Buffered control byte |
| load_ok_set | input | 1 | Pulse that arms load-okay |
| load_ok | output | 1 | Load-okay flag |
| period | input | PERIOD_W | PWM period in divided clock steps |
| sw_corr | input | 3 | Per-pair software-correction enable |
| pwm_count | output | PERIOD_W | Period counter value |
| cycle_start | output | 1 | One-clock pulse at the start of each PWM cycle |
| reload | output | 1 | One-clock pulse at the end of each load cycle |
| act_rate | output | 2 | Reload-rate code in use |
| act_div | output | 2 | Divider code in use |
| pair_sel | output | 3 | Per-pair duty register select |

## Verification
Two functions can fall in the same clock: the reload that clears load-okay and a new set pulse, and the cycle start that samples the correction selects and a software write. The bench measures the PWM period from earlier cycle starts. It then raises the set pulse, or the write strobe, in exactly the clock before a predicted wrap edge. It judges the result from `load_ok` after that reload edge, and from `pair_sel` at that cycle start and at the next one.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    localparam int CTL_W   = 8;
    localparam int PAIRS   = 3;
    localparam int CODE_W  = 2;

    typedef struct packed {
        logic [CODE_W-1:0] rate;
        logic [PAIRS-1:0]  corr;   // corr[0] is pair 1
        logic [CODE_W-1:0] div;
    } ctl_fields_t;

    typedef enum logic {
        LD_COUNT,
        LD_FINAL
    } ld_state_e;

    typedef enum logic {
        OK_IDLE,
        OK_ARMED
    } ok_state_e;

    function automatic ctl_fields_t ctl_unpack(input logic [CTL_W-1:0] b);
        ctl_fields_t f;
        f.rate    = b[7:6];
        f.corr[0] = b[4];
        f.corr[1] = b[3];
        f.corr[2] = b[2];
        f.div     = b[1:0];
        return f;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_pack(input ctl_fields_t f);
        logic [CTL_W-1:0] b;
        b      = '0;
        b[7:6] = f.rate;
        b[4]   = f.corr[0];
        b[3]   = f.corr[1];
        b[2]   = f.corr[2];
        b[1:0] = f.div;
        return b;
    endfunction

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int PERIOD_W = 12,
    parameter int CODE_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic [CODE_W-1:0]   div_code,
    output logic [PERIOD_W-1:0] count,
    output logic                wrap,
    output logic                cycle_start
);
    localparam int PS_W = (1 << CODE_W) - 1;

    logic [PS_W-1:0]     ps_cnt;
    logic [PS_W-1:0]     ps_last;
    logic [PERIOD_W-1:0] count_last;
    logic                tick;

    always_comb begin
        ps_last    = {PS_W{1'b1}} >> (PS_W - int'(div_code));
        count_last = (period == '0) ? '0 : period - PERIOD_W'(1);
        tick       = (ps_cnt >= ps_last);
        wrap       = tick && (count >= count_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_cnt      <= '0;
            count       <= '0;
            cycle_start <= 1'b0;
        end else begin
            cycle_start <= wrap;
            if (tick) begin
                ps_cnt <= '0;
                count  <= wrap ? '0 : count + PERIOD_W'(1);
            end else begin
                ps_cnt <= ps_cnt + PS_W'(1);
            end
        end
    end

    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (count == '0));

    a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> ((count == $past(count) + PERIOD_W'(1)) || (count == '0)));

endmodule

// File: rtl/pwm_load_seq.sv
module pwm_load_seq
    import pwm_reload_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              cycle_start,
    input  logic [CODE_W-1:0] rate_buf,
    input  logic              load_ok_set,
    output logic [CODE_W-1:0] rate_work,
    output logic              reload,
    output logic              ok_armed
);
    localparam int LC_W = (1 << CODE_W) - 1;

    ld_state_e         ld_state, ld_next;
    ok_state_e         ok_state, ok_next;
    logic [LC_W-1:0]   lc, lc_next;
    logic [LC_W-1:0]   len_last;
    logic [CODE_W-1:0] rate_next;
    logic              reload_next;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_state  <= LD_FINAL;
            ok_state  <= OK_IDLE;
            lc        <= '0;
            rate_work <= '0;
            reload    <= 1'b0;
        end else begin
            ld_state  <= ld_next;
            ok_state  <= ok_next;
            lc        <= lc_next;
            rate_work <= rate_next;
            reload    <= reload_next;
        end
    end

    // next-state and output process
    always_comb begin
        len_last    = {LC_W{1'b1}} >> (LC_W - int'(rate_work));
        ld_next     = ld_state;
        lc_next     = lc;
        rate_next   = rate_work;
        reload_next = 1'b0;
        unique case (ld_state)
            LD_COUNT: begin
                if (wrap) begin
                    lc_next = lc + LC_W'(1);
                    if (lc + LC_W'(1) == len_last) ld_next = LD_FINAL;
                end
            end
            LD_FINAL: begin
                if (wrap) begin
                    reload_next = 1'b1;
                    lc_next     = '0;
                    rate_next   = rate_buf;
                    ld_next     = (rate_buf == '0) ? LD_FINAL : LD_COUNT;
                end
            end
            default: ld_next = LD_FINAL;
        endcase

        ok_next = ok_state;
        unique case (ok_state)
            OK_IDLE:  if (load_ok_set) ok_next = OK_ARMED;
            OK_ARMED: if (reload_next && !load_ok_set) ok_next = OK_IDLE;
            default:  ok_next = OK_IDLE;
        endcase
        ok_armed = (ok_state == OK_ARMED);
    end

    a_r4_reload_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> cycle_start);

    a_r5_rate_moves_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_work) |-> reload);

    a_r7_ok_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> (ok_armed == $past(load_ok_set)));

endmodule

// File: rtl/pwm_ctl_bank.sv
module pwm_ctl_bank
    import pwm_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              wrap,
    input  logic              ok_armed,
    output logic [CTL_W-1:0]  rd_data,
    output logic [CODE_W-1:0] rate_buf,
    output logic [PAIRS-1:0]  corr_work,
    output logic [CODE_W-1:0] div_work
);
    ctl_fields_t shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow    <= '0;
            corr_work <= '0;
            div_work  <= '0;
        end else begin
            if (wr_en) shadow <= ctl_unpack(wr_data);
            if (wrap) begin
                corr_work <= shadow.corr;
                if (ok_armed) div_work <= shadow.div;
            end
        end
    end

    always_comb begin
        rd_data  = ctl_pack(shadow);
        rate_buf = shadow.rate;
    end

    a_r6_div_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_work) |-> ($past(wrap) && $past(ok_armed)));

    a_r8_corr_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_work) |-> $past(wrap));

endmodule

// File: rtl/pwm_reload_ctl.sv
module pwm_reload_ctl
    import pwm_reload_pkg::*;
#(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    input  logic                load_ok_set,
    output logic                load_ok,
    input  logic [PERIOD_W-1:0] period,
    input  logic [2:0]          sw_corr,
    output logic [PERIOD_W-1:0] pwm_count,
    output logic                cycle_start,
    output logic                reload,
    output logic [1:0]          act_rate,
    output logic [1:0]          act_div,
    output logic [2:0]          pair_sel
);
    logic              wrap;
    logic              ok_armed;
    logic [CODE_W-1:0] rate_buf;
    logic [PAIRS-1:0]  corr_work;

    pwm_ctl_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wrap      (wrap),
        .ok_armed  (ok_armed),
        .rd_data   (rd_data),
        .rate_buf  (rate_buf),
        .corr_work (corr_work),
        .div_work  (act_div)
    );

    pwm_period_counter #(.PERIOD_W(PERIOD_W), .CODE_W(CODE_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .period      (period),
        .div_code    (act_div),
        .count       (pwm_count),
        .wrap        (wrap),
        .cycle_start (cycle_start)
    );

    pwm_load_seq #(.CODE_W(CODE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .cycle_start (cycle_start),
        .rate_buf    (rate_buf),
        .load_ok_set (load_ok_set),
        .rate_work   (act_rate),
        .reload      (reload),
        .ok_armed    (ok_armed)
    );

    assign load_ok = ok_armed;

    generate
        for (genvar i = 0; i < PAIRS; i++) begin : g_pair
            assign pair_sel[i] = corr_work[i] & sw_corr[i];
        end
    endgenerate

    a_r9_sel_needs_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel & ~sw_corr) == '0);

endmodule

// File: tb/tb_pwm_reload_ctl.sv
`timescale 1ns/1ps
module tb_pwm_reload_ctl;
    localparam int PW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          load_ok_set = 1'b0;
    logic          load_ok;
    logic [PW-1:0] period = PW'(5);
    logic [2:0]    sw_corr = 3'b111;
    logic [PW-1:0] pwm_count;
    logic          cycle_start, reload;
    logic [1:0]    act_rate, act_div;
    logic [2:0]    pair_sel;

    int checks = 0;
    int failures = 0;
    int cur_div = 1;

    always #2.5 clk = ~clk;

    pwm_reload_ctl #(.PERIOD_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .load_ok_set(load_ok_set), .load_ok(load_ok), .period(period), .sw_corr(sw_corr),
        .pwm_count(pwm_count), .cycle_start(cycle_start), .reload(reload),
        .act_rate(act_rate), .act_div(act_div), .pair_sel(pair_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
    endtask

    // returns after the edge that raised cycle_start, sampled 1 ns later
    task automatic wait_cs(output int clocks);
        clocks = 0;
        do begin
            @(posedge clk); #1;
            clocks++;
        end while (!cycle_start);
    endtask

    task automatic t_reset;
        check(rd_data == 8'h00, "R2 rd_data", rd_data, 0);
        check(act_rate == 0 && act_div == 0, "R2 act fields", {act_rate, act_div}, 0);
        check(pair_sel == 0 && load_ok == 0, "R2 pair_sel/load_ok", {pair_sel, load_ok}, 0);
        check(reload == 0 && cycle_start == 0, "R2 pulses", {reload, cycle_start}, 0);
    endtask

    task automatic t_layout;
        write_reg(8'h3F);
        check(rd_data == 8'h1F, "R1 bit5 reads zero", rd_data, 8'h1F);
        check(act_div == 0 && pair_sel == 0, "R10 read is buffered only", {act_div, pair_sel}, 0);
        write_reg(8'h00);
        check(rd_data == 8'h00, "R10 read back", rd_data, 0);
    endtask

    task automatic t_counter;
        int n;
        wait_cs(n);
        check(pwm_count == 0, "R3 count zero at start", pwm_count, 0);
        @(posedge clk); #1;
        check(cycle_start == 0, "R3 single-clock pulse", cycle_start, 0);
        check(pwm_count == 1, "R3 count advances", pwm_count, 1);
        wait_cs(n);
        check(n == 4, "R3 period interval rest", n, 4);
        wait_cs(n);
        check(n == 5, "R3 period interval", n, 5);
    endtask

    task automatic t_reload_every;
        int n;
        for (int k = 0; k < 3; k++) begin
            wait_cs(n);
            check(reload == 1, "R4 rate 00 reload each cycle", reload, 1);
        end
    endtask

    task automatic t_ok_collision;
        int n;
        wait_cs(n);
        repeat (5 - 1) @(posedge clk);
        @(negedge clk); load_ok_set = 1'b1;
        @(posedge clk); #1;
        check(cycle_start && reload, "R7 edge is a reload", {cycle_start, reload}, 3);
        @(negedge clk); load_ok_set = 1'b0;
        check(load_ok == 1, "R7 set wins at reload", load_ok, 1);
        wait_cs(n);
        check(load_ok == 0, "R7 cleared by reload", load_ok, 0);
    endtask

    task automatic t_rate_change;
        int n;
        write_reg(8'h80);
        wait_cs(n);
        check(reload == 1 && act_rate == 2, "R5 rate taken at load end", act_rate, 2);
        for (int k = 1; k <= 4; k++) begin
            wait_cs(n);
            check(reload == (k == 4), "R4 rate 10 every 4th", reload, k == 4);
        end
        write_reg(8'h40);
        for (int k = 1; k <= 4; k++) begin
            wait_cs(n);
            check(act_rate == ((k == 4) ? 1 : 2), "R5 rate waits for load end", act_rate, (k == 4) ? 1 : 2);
            check(reload == (k == 4), "R5 old length governs", reload, k == 4);
        end
        wait_cs(n);
        check(reload == 0, "R4 rate 01 odd cycle", reload, 0);
        wait_cs(n);
        check(reload == 1, "R4 rate 01 every 2nd", reload, 1);
    endtask

    task automatic t_div_gate;
        int n;
        write_reg(8'h42);
        wait_cs(n);
        wait_cs(n);
        check(act_div == 0, "R6 no transfer without ok", act_div, 0);
        check(n == 5, "R6 interval unchanged", n, 5);
        @(negedge clk); load_ok_set = 1'b1;
        @(negedge clk); load_ok_set = 1'b0;
        check(load_ok == 1, "R7 set pulse arms", load_ok, 1);
        wait_cs(n);
        check(act_div == 2, "R6 transfer with ok", act_div, 2);
        cur_div = 4;
        wait_cs(n);
        check(n == 20, "R3 divided interval", n, 20);
        while (!reload) wait_cs(n);
        check(load_ok == 0, "R7 reload clears ok", load_ok, 0);
        write_reg(8'h41);
        for (int k = 0; k < 3; k++) wait_cs(n);
        check(act_div == 2, "R6 ignored while ok clear", act_div, 2);
    endtask

    task automatic t_corr;
        int n;
        write_reg(8'h55);
        check(pair_sel == 3'b000, "R8 not before start", pair_sel, 0);
        wait_cs(n);
        check(pair_sel == 3'b101, "R8 taken at start", pair_sel, 5);
        sw_corr = 3'b001; #1;
        check(pair_sel == 3'b001, "R9 masked by sw_corr", pair_sel, 1);
        sw_corr = 3'b111; #1;
        repeat (5 * cur_div - 1) @(posedge clk);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h49;
        @(posedge clk); #1;
        @(negedge clk); wr_en = 1'b0;
        check(cycle_start == 1 && pair_sel == 3'b101, "R8 write at start edge not taken", pair_sel, 5);
        wait_cs(n);
        check(pair_sel == 3'b010, "R8 taken at next start", pair_sel, 2);
    endtask

    initial begin
        #900000;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_layout();
        t_counter();
        t_reload_every();
        t_ok_collision();
        t_rate_change();
        t_div_gate();
        t_corr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule